// File: doc/BRIEF.md
# Multi-Level Interrupt Event Controller

The controller collects sixteen single-cycle event sources into sticky flags and routes them to three interrupt channels of fixed priority. Each channel has a 4-bit selector that names the one flag it watches. When a channel is accepted, the controller sends the core a one-cycle branch request that carries the channel number, and it marks the channel as executing until the core signals a return from that channel. The core can also park itself in a wait-for-interrupt state. The release strobe that ends that wait is asserted in the same cycle as the branch request, so the instruction the core has already fetched still completes before the branch takes effect.

Three of the event slots are filled inside the block. Slot 5 is a pin-edge detector. It takes one configuration byte: a 2-bit edge mode in the upper bits and a 6-bit pin index in the lower bits. Slot 14 fires on the push that fills the last entry of a hardware stack. Slot 15 fires on the pop that empties it. An attempt to overflow or underflow the stack raises nothing.

Stall and allow commands gate all channel acceptance. They take effect only when they are issued; the controller never stalls or allows on its own. A 32-bit status word exposes every flag, one busy bit per channel and all three selectors. Reading it changes no state.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset all flags are clear, all selectors are 0, no channel is busy, and irq_req_o and wait_rel_o are low.
- R2: A pulse on evt_i[k] sets flag k in the next cycle, for k other than 5, 14 and 15; those three inputs are ignored. A flag stays set until it is cleared. Flag 0 can be set but can never be selected.
- R3: A selector value of 0 disables its channel. Writing a nonzero selector value v clears flag v in the same cycle.
- R4: When channel c (1..3) is accepted, irq_req_o pulses for one cycle with irq_chan_o = c, the selected flag is cleared and the channel's busy bit is set. An event that arrives in the same cycle as the clear leaves the flag set. The request appears two cycles after the event pulse.
- R5: Channel 3 has the highest priority and channel 1 the lowest. A channel is accepted only if no channel at its own level or above is executing, so a higher channel can preempt a lower one.
- R6: An event that arrives while its channel is executing stays latched. The channel re-enters only after reti_i for that channel; the request follows two cycles after reti_i.
- R7: stall_i blocks acceptance from the cycle it is issued until allow_i is issued. Pending flags are kept. The first request after allow_i comes two cycles later.
- R8: When wait_i is high and a channel is accepted, wait_rel_o is high in exactly the cycle in which irq_req_o is high. wait_rel_o is never high without irq_req_o.
- R9: The status word is laid out as follows: bits [15:0] hold the flags; bits 16, 17 and 18 are the busy bits of channels 1, 2 and 3 (busy means pending or executing); bits [22:19], [26:23] and [30:27] hold selectors 1, 2 and 3; bit 31 is 0. Reading the word changes nothing.
- R10: The edge configuration byte holds the mode in bits [7:6] (00 none, 01 rising, 10 falling, 11 either) and the pin index in bits [5:0]. The selected pin passes through two synchroniser flops, so an edge sets flag 5 three cycles after the pin changes. Other pins and non-matching edges are ignored.
- R11: Flag 14 is raised only by a push that takes the stack count from depth-1 to depth. Flag 15 is raised only by a pop that takes it from 1 to 0. A push when the stack is full and a pop when it is empty change nothing, and a push and pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Single-cycle event pulses, one per slot |
| pin_i | input | 64 | Asynchronous pins watched by the edge detector |
| edge_cfg_we_i | input | 1 | Write strobe for the edge configuration |
| edge_cfg_i | input | 8 | Edge mode in [7:6], pin index in [5:0] |
| sel_we_i | input | 3 | Per-channel selector write strobe (bit 0 = channel 1) |
| sel_i | input | 4 | Selector value to write |
| stall_i | input | 1 | Stall command |
| allow_i | input | 1 | Allow command |
| wait_i | input | 1 | Core is waiting for an interrupt |
| reti_i | input | 3 | Per-channel return from interrupt |
| push_i | input | 1 | Stack push |
| pop_i | input | 1 | Stack pop |
| irq_req_o | output | 1 | Branch request pulse |
| irq_chan_o | output | 2 | Accepted channel number, 1 to 3 |
| wait_rel_o | output | 1 | Wait-for-interrupt release strobe |
| status_o | output | 32 | Flags, busy bits and selectors |

## Verification
The assertions check on every cycle the properties that involve only the ports and the executing set. Every request carries a valid channel that is marked executing. No request ever starts while its own channel or a higher one was executing. No request appears in the cycle after a stall command. The wait release never comes without a request. Flags 14 and 15 rise only after a lone push or a lone pop. The bench scenarios are needed for the rest, which depends on history: the exact fill and drain counts, the latching and later re-entry of events during a handler, the preemption order, the three-cycle synchroniser latency and the edge modes, the recovery after allow, and the bit positions of the status word.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;
  localparam int unsigned NUM_EVT     = 16;
  localparam int unsigned NUM_CH      = 3;
  localparam int unsigned SEL_W       = 4;
  localparam int unsigned CH_W        = 2;
  localparam int unsigned STATUS_W    = 32;
  localparam int unsigned EVT_PIN     = 5;
  localparam int unsigned EVT_FULL    = 14;
  localparam int unsigned EVT_EMPTY   = 15;
  localparam int unsigned ST_BUSY_LSB = NUM_EVT;
  localparam int unsigned ST_SEL_LSB  = NUM_EVT + NUM_CH;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
  typedef logic [SEL_W-1:0]   sel_t;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
  import irq_event_pkg::*;
#(
  parameter  int unsigned NUM_PINS = 64,
  localparam int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_we_i,
  input  logic [IDX_W+1:0]    cfg_i,
  output logic                evt_o
);
  logic [NUM_PINS-1:0] sync1_q, sync2_q;
  edge_mode_e          mode_q;
  logic [IDX_W-1:0]    idx_q;
  logic                prev_q;
  logic                cur;

  assign cur = sync2_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      mode_q  <= EDGE_OFF;
      idx_q   <= '0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      if (cfg_we_i) begin
        mode_q <= edge_mode_e'(cfg_i[IDX_W+1:IDX_W]);
        idx_q  <= cfg_i[IDX_W-1:0];
        // seed history from the new pin so a switch is not seen as an edge
        prev_q <= sync2_q[cfg_i[IDX_W-1:0]];
      end else begin
        prev_q <= cur;
      end
    end
  end

  always_comb begin
    unique case (mode_q)
      EDGE_RISE: evt_o = cur & ~prev_q;
      EDGE_FALL: evt_o = ~cur & prev_q;
      EDGE_ANY:  evt_o = cur ^ prev_q;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_stack_mon.sv
module irq_stack_mon #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  output logic full_evt_o,
  output logic empty_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push     = push_i & ~pop_i & (cnt_q != CNT_W'(DEPTH));
  assign do_pop      = pop_i & ~push_i & (cnt_q != '0);
  assign full_evt_o  = do_push & (cnt_q == CNT_W'(DEPTH - 1));
  assign empty_evt_o = do_pop & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (do_push) cnt_q <= cnt_q + CNT_W'(1);
    else if (do_pop)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] active_i,
  input  logic              block_i,
  output logic [NUM_CH-1:0] grant_o
);
  logic [NUM_CH-1:0] elig;

  // eligible only when nothing at this level or above is executing
  for (genvar c = 0; c < NUM_CH; c++) begin : g_elig
    assign elig[c] = pend_i[c] & ~|(active_i >> c);
  end

  always_comb begin
    grant_o = '0;
    if (!block_i) begin
      for (int c = NUM_CH - 1; c >= 0; c--) begin
        if (elig[c] && grant_o == '0) grant_o[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_event_pkg::*;
#(
  parameter  int unsigned NUM_PINS    = 64,
  parameter  int unsigned STACK_DEPTH = 8,
  localparam int unsigned IDX_W       = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                edge_cfg_we_i,
  input  logic [IDX_W+1:0]    edge_cfg_i,
  input  logic [NUM_CH-1:0]   sel_we_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                stall_i,
  input  logic                allow_i,
  input  logic                wait_i,
  input  logic [NUM_CH-1:0]   reti_i,
  input  logic                push_i,
  input  logic                pop_i,
  output logic                irq_req_o,
  output logic [CH_W-1:0]     irq_chan_o,
  output logic                wait_rel_o,
  output logic [STATUS_W-1:0] status_o
);
  evt_vec_t          flag_q, new_evt, clr_evt;
  sel_t              sel_q [NUM_CH];
  logic [NUM_CH-1:0] active_q, pend, grant;
  logic              stalled_q, pin_evt, full_evt, empty_evt;
  logic [CH_W-1:0]   chan_d;

  irq_pin_edge #(.NUM_PINS(NUM_PINS)) u_pin_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pin_i),
    .cfg_we_i (edge_cfg_we_i),
    .cfg_i    (edge_cfg_i),
    .evt_o    (pin_evt)
  );

  irq_stack_mon #(.DEPTH(STACK_DEPTH)) u_stack_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .full_evt_o  (full_evt),
    .empty_evt_o (empty_evt)
  );

  always_comb begin
    new_evt            = evt_i;
    new_evt[EVT_PIN]   = pin_evt;
    new_evt[EVT_FULL]  = full_evt;
    new_evt[EVT_EMPTY] = empty_evt;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    assign pend[c] = (sel_q[c] != '0) & flag_q[sel_q[c]];
  end

  irq_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .pend_i   (pend),
    .active_i (active_q),
    .block_i  (stall_i | stalled_q),
    .grant_o  (grant)
  );

  always_comb begin
    clr_evt = '0;
    chan_d  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grant[c]) begin
        clr_evt[sel_q[c]] = 1'b1;
        chan_d            = CH_W'(c + 1);
      end
      if (sel_we_i[c] && sel_i != '0) clr_evt[sel_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q     <= '0;
      active_q   <= '0;
      stalled_q  <= 1'b0;
      irq_req_o  <= 1'b0;
      irq_chan_o <= '0;
      wait_rel_o <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) sel_q[c] <= '0;
    end else begin
      // a new event wins over a same-cycle clear
      flag_q   <= (flag_q & ~clr_evt) | new_evt;
      active_q <= (active_q & ~reti_i) | grant;
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel_we_i[c]) sel_q[c] <= sel_i;
      end
      if (stall_i)      stalled_q <= 1'b1;
      else if (allow_i) stalled_q <= 1'b0;
      irq_req_o  <= |grant;
      irq_chan_o <= chan_d;
      wait_rel_o <= wait_i & |grant;
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[NUM_EVT-1:0] = flag_q;
    for (int c = 0; c < NUM_CH; c++) begin
      status_o[ST_BUSY_LSB + c]               = active_q[c] | pend[c];
      status_o[ST_SEL_LSB + c*SEL_W +: SEL_W] = sel_q[c];
    end
  end
endmodule

// File: rtl/irq_event_ctrl_chk.sv
module irq_event_ctrl_chk
  import irq_event_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                stall_i,
  input logic                push_i,
  input logic                pop_i,
  input logic                irq_req_o,
  input logic [CH_W-1:0]     irq_chan_o,
  input logic                wait_rel_o,
  input logic [STATUS_W-1:0] status_o,
  input logic [NUM_CH-1:0]   active_i
);
  AST_REQ_CHAN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_chan_o != '0 && irq_chan_o <= CH_W'(NUM_CH))); // R4

  AST_REQ_MARKS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> active_i[irq_chan_o - 2'd1]); // R4

  AST_NO_PREEMPT_SAME_OR_HIGHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (($past(active_i) >> (irq_chan_o - 2'd1)) == 3'b000)); // R5

  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stall_i) |-> !irq_req_o); // R7

  AST_WAIT_REL_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_rel_o |-> irq_req_o); // R8

  AST_FULL_ONLY_ON_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[EVT_FULL]) |-> ($past(push_i) && !$past(pop_i))); // R11

  AST_EMPTY_ONLY_ON_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[EVT_EMPTY]) |-> ($past(pop_i) && !$past(push_i))); // R11
endmodule

bind irq_event_ctrl irq_event_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stall_i    (stall_i),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .irq_req_o  (irq_req_o),
  .irq_chan_o (irq_chan_o),
  .wait_rel_o (wait_rel_o),
  .status_o   (status_o),
  .active_i   (active_q)
);

// File: tb/irq_event_ctrl_bench.sv
module irq_event_ctrl_bench;
  import irq_event_pkg::*;
  localparam int unsigned NP = 64;
  localparam int unsigned SD = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] evt;
  logic [NP-1:0] pins;
  logic        edge_we;
  logic [7:0]  edge_cfg;
  logic [2:0]  sel_we, reti;
  logic [3:0]  sel;
  logic        stall, allow, wt, push, pop;
  logic        req, rel;
  logic [1:0]  chan;
  logic [31:0] status;

  int n_cmp = 0, n_bad = 0;
  int scnt = 0;
  logic [15:0] ef;

  always #2.5 clk = ~clk;

  irq_event_ctrl #(.NUM_PINS(NP), .STACK_DEPTH(SD)) u_irq_event_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .pin_i(pins),
    .edge_cfg_we_i(edge_we), .edge_cfg_i(edge_cfg), .sel_we_i(sel_we), .sel_i(sel),
    .stall_i(stall), .allow_i(allow), .wait_i(wt), .reti_i(reti),
    .push_i(push), .pop_i(pop), .irq_req_o(req), .irq_chan_o(chan),
    .wait_rel_o(rel), .status_o(status)
  );

  function automatic logic [31:0] exp_status(logic [15:0] f, logic [2:0] busy,
                                              logic [3:0] s1, logic [3:0] s2, logic [3:0] s3);
    return {1'b0, s3, s2, s1, busy, f};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    evt = '0; edge_we = 1'b0; sel_we = '0; stall = 1'b0; allow = 1'b0;
    reti = '0; push = 1'b0; pop = 1'b0;
  endtask

  task automatic wsel(int c, logic [3:0] v);
    sel_we = 3'b001 << c; sel = v; tick(); idle();
  endtask

  task automatic pulse_evt(int k);
    evt = 16'h1 << k; tick(); idle();
  endtask

  task automatic do_reti(int c);
    reti = 3'b001 << c; tick(); idle();
  endtask

  task automatic clear_all();
    for (int k = 1; k < 16; k++) wsel(0, 4'(k));
    wsel(0, 4'd0);
  endtask

  task automatic set_edge(logic [1:0] m, int p);
    edge_we = 1'b1; edge_cfg = {m, 6'(p)}; tick(); idle();
  endtask

  task automatic no_req(string tag, int n);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(tag, {31'd0, req}, 32'd0);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    idle(); wt = 1'b0; pins = '0; sel = '0; edge_cfg = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 status", status, 32'd0);
    chk("R1 req", {31'd0, req}, 32'd0);
    chk("R1 rel", {31'd0, rel}, 32'd0);

    // R2 / R11 random events and stack traffic, all channels disabled
    ef = '0;
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 24; i++) begin
        logic [15:0] ev;
        logic        pu, po, fe, ee;
        ev = ($urandom % 3 == 0) ? (16'h1 << ($urandom % 15 + 1)) : 16'h0;
        pu = ($urandom % 2 == 0);
        po = ($urandom % 3 == 0);
        fe = pu && !po && scnt == SD - 1;
        ee = po && !pu && scnt == 1;
        if (pu && !po && scnt < SD) scnt++;
        else if (po && !pu && scnt > 0) scnt--;
        ef |= (ev & 16'h3FDF) | (16'(fe) << 14) | (16'(ee) << 15);
        evt = ev; push = pu; pop = po;
        tick(); idle();
        chk("R2/R11 random flags", {16'd0, status[15:0]}, {16'd0, ef});
      end
      clear_all();
      ef = '0;
      chk("R3 clear via selector writes", {16'd0, status[15:0]}, 32'd0);
    end

    // drain stack to a known empty state
    while (scnt > 0) begin pop = 1'b1; tick(); idle(); scnt--; end
    clear_all();

    // R3 disabled channel
    pulse_evt(3);
    no_req("R3 sel0 disabled no req", 4);
    chk("R3 flag kept", {31'd0, status[3]}, 32'd1);
    wsel(0, 4'd3);
    chk("R3 sel write clears flag", status, exp_status(16'h0, 3'b000, 4'd3, 4'd0, 4'd0));

    // R4 acceptance, same-cycle event kept; R6 latched during handler
    evt = 16'h0008; tick(); idle();
    chk("R4 no req one cycle after event", {31'd0, req}, 32'd0);
    evt = 16'h0008; tick(); idle();
    chk("R4 req", {31'd0, req}, 32'd1);
    chk("R4 chan", {30'd0, chan}, 32'd1);
    chk("R4 same-cycle event kept", {31'd0, status[3]}, 32'd1);
    chk("R4 busy ch1", {31'd0, status[16]}, 32'd1);
    tick();
    chk("R4 single pulse", {31'd0, req}, 32'd0);
    no_req("R6 no re-entry before reti", 4);
    do_reti(0);
    chk("R6 no req in cycle after reti", {31'd0, req}, 32'd0);
    tick();
    chk("R6 re-entry after reti", {29'd0, req, chan}, {29'd0, 1'b1, 2'd1});
    chk("R6 flag cleared on re-entry", {31'd0, status[3]}, 32'd0);
    do_reti(0);
    wsel(0, 4'd0);

    // R5 priority and preemption
    clear_all();
    wsel(0, 4'd1); wsel(1, 4'd2); wsel(2, 4'd4);
    evt = 16'h0016; tick(); idle(); tick();
    chk("R5 highest first", {29'd0, req, chan}, {29'd0, 1'b1, 2'd3});
    no_req("R5 ch3 blocks lower", 3);
    do_reti(2); tick();
    chk("R5 ch2 after ch3 returns", {29'd0, req, chan}, {29'd0, 1'b1, 2'd2});
    pulse_evt(4); tick();
    chk("R5 ch3 preempts ch2", {29'd0, req, chan}, {29'd0, 1'b1, 2'd3});
    do_reti(2);
    no_req("R5 ch1 blocked while ch2 executes", 2);
    do_reti(1); tick();
    chk("R5 ch1 last", {29'd0, req, chan}, {29'd0, 1'b1, 2'd1});
    do_reti(0);

    // R7 stall / allow
    wsel(0, 4'd9);
    stall = 1'b1; tick(); idle();
    pulse_evt(9);
    no_req("R7 stalled no req", 5);
    chk("R7 pending kept while stalled", {30'd0, status[16], status[9]}, 32'd3);
    allow = 1'b1; tick(); idle();
    chk("R7 no req right after allow", {31'd0, req}, 32'd0);
    tick();
    chk("R7 req after allow", {29'd0, req, chan}, {29'd0, 1'b1, 2'd1});
    do_reti(0);

    // R8 wait release
    wt = 1'b1;
    pulse_evt(9);
    chk("R8 no release before req", {31'd0, rel}, 32'd0);
    tick();
    chk("R8 release with req", {30'd0, req, rel}, 32'd3);
    wt = 1'b0;
    tick();
    chk("R8 release single cycle", {31'd0, rel}, 32'd0);
    do_reti(0);
    pulse_evt(9); tick();
    chk("R8 no release without wait", {30'd0, req, rel}, 32'd2);
    do_reti(0);

    // R9 status layout, non-destructive read
    clear_all();
    wsel(0, 4'd9); wsel(1, 4'd10); wsel(2, 4'd11);
    pulse_evt(12); pulse_evt(7);
    chk("R9 layout idle", status, exp_status(16'h1080, 3'b000, 4'd9, 4'd10, 4'd11));
    tick();
    chk("R9 read again unchanged", status, exp_status(16'h1080, 3'b000, 4'd9, 4'd10, 4'd11));
    stall = 1'b1; tick(); idle();
    pulse_evt(10);
    chk("R9 pending busy ch2", status, exp_status(16'h1480, 3'b010, 4'd9, 4'd10, 4'd11));
    allow = 1'b1; tick(); idle(); tick();
    chk("R9 executing busy ch2", status, exp_status(16'h1080, 3'b010, 4'd9, 4'd10, 4'd11));
    do_reti(1);
    chk("R9 idle after reti", status, exp_status(16'h1080, 3'b000, 4'd9, 4'd10, 4'd11));
    wsel(1, 4'd0); wsel(2, 4'd0);
    clear_all();

    // R10 edge detector
    set_edge(2'b01, 37);
    pins[37] = 1'b1; tick(); tick();
    chk("R10 not before sync latency", {31'd0, status[5]}, 32'd0);
    tick();
    chk("R10 rising sets flag", {31'd0, status[5]}, 32'd1);
    wsel(0, 4'd5); wsel(0, 4'd0);
    pins[37] = 1'b0; repeat (4) tick();
    chk("R10 falling ignored in rising mode", {31'd0, status[5]}, 32'd0);
    pins[36] = 1'b1; repeat (4) tick();
    chk("R10 other pin ignored", {31'd0, status[5]}, 32'd0);
    set_edge(2'b10, 37);
    pins[37] = 1'b1; repeat (4) tick();
    chk("R10 rising ignored in falling mode", {31'd0, status[5]}, 32'd0);
    pins[37] = 1'b0; repeat (4) tick();
    chk("R10 falling sets flag", {31'd0, status[5]}, 32'd1);
    wsel(0, 4'd5); wsel(0, 4'd0);
    set_edge(2'b11, 63);
    pins[63] = 1'b1; repeat (4) tick();
    chk("R10 either mode rise pin63", {31'd0, status[5]}, 32'd1);
    wsel(0, 4'd5); wsel(0, 4'd0);
    pins[63] = 1'b0; repeat (4) tick();
    chk("R10 either mode fall pin63", {31'd0, status[5]}, 32'd1);
    wsel(0, 4'd5); wsel(0, 4'd0);
    set_edge(2'b00, 63);
    pins[63] = 1'b1; repeat (4) tick();
    chk("R10 mode none ignored", {31'd0, status[5]}, 32'd0);

    // R11 stack fill / drain
    clear_all();
    for (int i = 1; i <= SD; i++) begin
      push = 1'b1; tick(); idle();
      chk("R11 full only on last push", {31'd0, status[14]}, (i == SD) ? 32'd1 : 32'd0);
    end
    wsel(0, 4'd14); wsel(0, 4'd0);
    push = 1'b1; tick(); idle();
    chk("R11 push when full no event", {31'd0, status[14]}, 32'd0);
    push = 1'b1; pop = 1'b1; tick(); idle();
    for (int i = 1; i <= SD; i++) begin
      pop = 1'b1; tick(); idle();
      chk("R11 empty only on last pop", {31'd0, status[15]}, (i == SD) ? 32'd1 : 32'd0);
    end
    wsel(0, 4'd15); wsel(0, 4'd0);
    pop = 1'b1; tick(); idle();
    chk("R11 pop when empty no event", {30'd0, status[15:14]}, 32'd0);

    finish_run();
  end
endmodule